// File: doc/BRIEF.md
# Programmable-ratio sample demultiplexer

This block takes a stream of samples and deals consecutive samples out across a bank of parallel output ports, so that logic downstream can work at a fraction of the sample rate. The grouping ratio is either one sample per port over four ports (1:4) or over eight ports (1:8). Samples are 10 bits wide. A narrow 8-bit mode carries the sample on the upper eight bits and forces the two lowest bits of every port to zero. A port-selection counter records where in the current group the next sample goes. Once a group is complete, every active port is loaded in the same clock. A data-ready strobe rises in that clock and has a 50% duty cycle over one group period.

The input can run in two clock modes. In full-rate mode each handshake carries one sample, on lane 0. In half-rate mode each handshake carries two samples: lane 0 holds the older (even) sample and lane 1 holds the newer (odd) one. An active-high asynchronous reset clears the block. A synchronous realignment reset moves the port-selection counter back to the first port and leaves the data already in flight alone. The ratio, the width and the clock mode are captured only while the asynchronous reset is held.

The input side is a valid/ready interface. `in_ready` is high whenever neither reset is asserted, so the block applies no back-pressure in normal running. A sample is taken only in a clock where `in_valid` and `in_ready` are both high. Idle cycles between samples do not change the grouping. The output side has no back-pressure. The ports hold their contents until the next group is loaded, and the data-ready strobe marks each new word.

Top module: `sample_demux`

## Requirements
- R1: Port p occupies bits [10p+9:10p] of `port_data`, with port A at p=0. In 1:8 mode (`ratio8_i`=1) a group fills ports A–H. In 1:4 mode (`ratio8_i`=0) a group fills ports A–D, and ports E–H read zero.
- R2: Within a group, port A receives the oldest sample and the last active port receives the newest. In half-rate mode lane 0 (`in_dat0`) is the older sample of the pair and lane 1 (`in_dat1`) the newer.
- R3: In 8-bit mode (`wide_i`=0) bits [1:0] of every port read zero and bits [9:2] carry the sample. In 10-bit mode all ten bits are passed through.
- R4: In full-rate mode (`half_rate_i`=0) each accepted handshake supplies one sample, from lane 0. In half-rate mode (`half_rate_i`=1) each handshake supplies two samples.
- R5: When the last sample of a group is accepted on clock edge k, all active ports and the data-ready strobe change together on edge k+2, in either ratio.
- R6: The ports hold their values between group updates.
- R7: `dr` rises on the edge that loads the ports. It stays high for N/2 clocks in full-rate mode and N/4 clocks in half-rate mode, where N is 4 or 8 samples per group, and then goes low. This is half of a group period when input is continuous.
- R8: While `arst` is high, the ports and `dr` read zero at once, without waiting for a clock edge, and the port-selection counter returns to port A.
- R9: `srst` sampled high on a clock edge returns the port-selection counter to port A and drops any partial group. `in_ready` is low while `srst` is high. Port contents and groups already in the pipeline are untouched.
- R10: The ratio, width and clock-mode selects are captured only while `arst` is high. Changing them at any other time has no effect.
- R11: A sample is accepted only when `in_valid` and `in_ready` are both high. `in_ready` is high whenever neither reset is asserted. Idle cycles inside a group do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst | input | 1 | Asynchronous reset, active high |
| srst | input | 1 | Synchronous realignment reset, active high |
| ratio8_i | input | 1 | 1 selects 1:8, 0 selects 1:4 (captured during arst) |
| wide_i | input | 1 | 1 selects 10-bit samples, 0 selects 8-bit (captured during arst) |
| half_rate_i | input | 1 | 1 selects two samples per handshake (captured during arst) |
| in_valid | input | 1 | Input handshake valid |
| in_ready | output | 1 | Input handshake ready |
| in_dat0 | input | SAMPLE_W | Sample lane 0 (older sample of a pair) |
| in_dat1 | input | SAMPLE_W | Sample lane 1 (newer sample, half-rate only) |
| port_data | output | NPORT*SAMPLE_W | Ports A..H, port A in the lowest bits |
| dr | output | 1 | Data-ready strobe |

## Verification
The bench builds the block at its default parameters: 10-bit samples, an 8-bit narrow mode and eight ports. This makes all eight combinations of ratio, width and clock mode reachable, and the vector table visits each of them once. Every vector checks the two-clock latency, the strobe's high time and the hold behaviour. Sample bases near the top of the 10-bit range make the values wrap inside a group. Directed cases cover handshakes with gaps, a realignment reset in the middle of a group, select changes without a reset, and an asynchronous reset seen before any clock edge.

// File: rtl/sdmx_pkg.sv
package sdmx_pkg;
  // Number of samples in one group for a given ratio select.
  function automatic int group_len(input logic r8, input int nport);
    return r8 ? nport : nport / 2;
  endfunction
endpackage

// File: rtl/sdmx_cfg.sv
module sdmx_cfg (
  input  logic clk,
  input  logic arst,
  input  logic r8_i,
  input  logic w10_i,
  input  logic hr_i,
  output logic r8_o,
  output logic w10_o,
  output logic hr_o
);
  // Selects are loaded on every clock while arst holds, then frozen.
  always_ff @(posedge clk) begin
    if (arst) begin
      r8_o  <= r8_i;
      w10_o <= w10_i;
      hr_o  <= hr_i;
    end
  end
endmodule

// File: rtl/sdmx_collect.sv
module sdmx_collect #(
  parameter int SAMPLE_W = 10,
  parameter int NPORT    = 8
) (
  input  logic                      clk,
  input  logic                      arst,
  input  logic                      srst,
  input  logic                      r8,
  input  logic                      hr,
  input  logic                      acc,
  input  logic [SAMPLE_W-1:0]       d0,
  input  logic [SAMPLE_W-1:0]       d1,
  output logic [NPORT*SAMPLE_W-1:0] buf_o,
  output logic [$clog2(NPORT)-1:0]  pos_o,
  output logic                      grp_o
);
  import sdmx_pkg::*;
  localparam int SEL_W = $clog2(NPORT);
  localparam int CW    = SEL_W + 1;

  logic [SEL_W-1:0] pos_q;
  logic [CW-1:0]    lim, step, nxt;
  logic             grp_q;

  always_comb begin
    lim  = CW'(group_len(r8, NPORT));
    step = hr ? CW'(2) : CW'(1);
    nxt  = {1'b0, pos_q} + step;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      pos_q <= '0;
      grp_q <= 1'b0;
    end else begin
      grp_q <= 1'b0;
      if (srst) begin
        pos_q <= '0;
      end else if (acc) begin
        if (nxt >= lim) begin
          pos_q <= '0;
          grp_q <= 1'b1;
        end else begin
          pos_q <= nxt[SEL_W-1:0];
        end
      end
    end
  end

  for (genvar s = 0; s < NPORT; s++) begin : g_slot
    logic [SAMPLE_W-1:0] slot_q;
    always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
        slot_q <= '0;
      end else if (acc) begin
        if (SEL_W'(s) == pos_q)
          slot_q <= d0;
        else if (hr && (SEL_W'(s) == pos_q + 1'b1))
          slot_q <= d1;
      end
    end
    assign buf_o[s*SAMPLE_W +: SAMPLE_W] = slot_q;
  end

  assign pos_o = pos_q;
  assign grp_o = grp_q;
endmodule

// File: rtl/sdmx_outstage.sv
module sdmx_outstage #(
  parameter int SAMPLE_W = 10,
  parameter int NARROW_W = 8,
  parameter int NPORT    = 8
) (
  input  logic                      clk,
  input  logic                      arst,
  input  logic                      r8,
  input  logic                      w10,
  input  logic                      grp,
  input  logic [NPORT*SAMPLE_W-1:0] buf_i,
  output logic [NPORT*SAMPLE_W-1:0] ports_o,
  output logic                      upd_o
);
  localparam int LOWB = SAMPLE_W - NARROW_W;
  localparam logic [SAMPLE_W-1:0] KEEP = {SAMPLE_W{1'b1}} << LOWB;

  logic [NPORT*SAMPLE_W-1:0] hold_q;
  logic                      hold_vld_q;

  // Stage 1: freeze the completed group so the collector can refill.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      hold_vld_q <= grp;
      if (grp) hold_q <= buf_i;
    end
  end

  // Stage 2: load every port in the same clock, masking by mode.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [SAMPLE_W-1:0] v, m, port_q;
    always_comb begin
      v = hold_q[p*SAMPLE_W +: SAMPLE_W];
      m = w10 ? v : (v & KEEP);
    end
    if (p >= NPORT / 2) begin : g_upper
      always_ff @(posedge clk or posedge arst) begin
        if (arst)            port_q <= '0;
        else if (hold_vld_q) port_q <= r8 ? m : '0;
      end
    end else begin : g_lower
      always_ff @(posedge clk or posedge arst) begin
        if (arst)            port_q <= '0;
        else if (hold_vld_q) port_q <= m;
      end
    end
    assign ports_o[p*SAMPLE_W +: SAMPLE_W] = port_q;
  end

  assign upd_o = hold_vld_q;
endmodule

// File: rtl/sdmx_ready.sv
module sdmx_ready #(
  parameter int NPORT = 8
) (
  input  logic clk,
  input  logic arst,
  input  logic r8,
  input  logic hr,
  input  logic upd,
  output logic dr
);
  import sdmx_pkg::*;
  localparam int SEL_W = $clog2(NPORT);

  logic [SEL_W-1:0] cnt_q, ld;
  logic             dr_q;
  int               high_clks;

  always_comb begin
    high_clks = hr ? group_len(r8, NPORT) / 4 : group_len(r8, NPORT) / 2;
    ld        = SEL_W'(high_clks - 1);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      dr_q  <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      dr_q  <= 1'b1;
      cnt_q <= ld;
    end else if (dr_q) begin
      if (cnt_q == '0) dr_q  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dr = dr_q;
endmodule

// File: rtl/sample_demux.sv
module sample_demux #(
  parameter int SAMPLE_W = 10,
  parameter int NARROW_W = 8,
  parameter int NPORT    = 8
) (
  input  logic                      clk,
  input  logic                      arst,
  input  logic                      srst,
  input  logic                      ratio8_i,
  input  logic                      wide_i,
  input  logic                      half_rate_i,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SAMPLE_W-1:0]       in_dat0,
  input  logic [SAMPLE_W-1:0]       in_dat1,
  output logic [NPORT*SAMPLE_W-1:0] port_data,
  output logic                      dr
);
  localparam int SEL_W = $clog2(NPORT);

  logic                      cfg_r8, cfg_w10, cfg_hr;
  logic                      acc, grp, upd;
  logic [SEL_W-1:0]          pos;
  logic [NPORT*SAMPLE_W-1:0] gbuf;

  assign in_ready = ~arst & ~srst;
  assign acc      = in_valid & in_ready;

  sdmx_cfg u_cfg (
    .clk(clk), .arst(arst),
    .r8_i(ratio8_i), .w10_i(wide_i), .hr_i(half_rate_i),
    .r8_o(cfg_r8), .w10_o(cfg_w10), .hr_o(cfg_hr)
  );

  sdmx_collect #(.SAMPLE_W(SAMPLE_W), .NPORT(NPORT)) u_collect (
    .clk(clk), .arst(arst), .srst(srst), .r8(cfg_r8), .hr(cfg_hr),
    .acc(acc), .d0(in_dat0), .d1(in_dat1),
    .buf_o(gbuf), .pos_o(pos), .grp_o(grp)
  );

  sdmx_outstage #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .NPORT(NPORT)) u_out (
    .clk(clk), .arst(arst), .r8(cfg_r8), .w10(cfg_w10),
    .grp(grp), .buf_i(gbuf), .ports_o(port_data), .upd_o(upd)
  );

  sdmx_ready #(.NPORT(NPORT)) u_ready (
    .clk(clk), .arst(arst), .r8(cfg_r8), .hr(cfg_hr), .upd(upd), .dr(dr)
  );
endmodule

// File: rtl/sdmx_chk.sv
module sdmx_chk #(
  parameter int SAMPLE_W = 10,
  parameter int NARROW_W = 8,
  parameter int NPORT    = 8
) (
  input logic                      clk,
  input logic                      arst,
  input logic                      srst,
  input logic                      r8,
  input logic                      w10,
  input logic [$clog2(NPORT)-1:0]  pos,
  input logic                      grp,
  input logic                      dr,
  input logic [NPORT*SAMPLE_W-1:0] port_data
);
  localparam int LOWB = SAMPLE_W - NARROW_W;
  localparam int HALF = NPORT / 2;

  logic low_or;
  always_comb begin
    low_or = 1'b0;
    for (int p = 0; p < NPORT; p++)
      low_or = low_or | (|port_data[p*SAMPLE_W +: LOWB]);
  end

  // R9
  realign_pos_chk: assert property (@(posedge clk) disable iff (arst)
    srst |=> (pos == '0));

  // R5
  latency_two_chk: assert property (@(posedge clk) disable iff (arst)
    grp |=> ##1 $rose(dr));

  // R6
  hold_ports_chk: assert property (@(posedge clk) disable iff (arst)
    !$stable(port_data) |-> $rose(dr));

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (arst)
    !r8 |-> (port_data[NPORT*SAMPLE_W-1:HALF*SAMPLE_W] == '0));

  // R3
  narrow_low_chk: assert property (@(posedge clk) disable iff (arst)
    !w10 |-> !low_or);
endmodule

bind sample_demux sdmx_chk #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .NPORT(NPORT)) u_chk (
  .clk(clk), .arst(arst), .srst(srst), .r8(cfg_r8), .w10(cfg_w10),
  .pos(pos), .grp(grp), .dr(dr), .port_data(port_data)
);

// File: tb/sample_demux_bench.sv
module sample_demux_bench;
  localparam int W = 10;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          arst = 1'b1, srst = 1'b0;
  logic          ratio8_i = 1'b1, wide_i = 1'b1, half_rate_i = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_dat0 = '0, in_dat1 = '0;
  logic [NP*W-1:0] port_data;
  logic          dr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sample_demux u_sample_demux (
    .clk(clk), .arst(arst), .srst(srst),
    .ratio8_i(ratio8_i), .wide_i(wide_i), .half_rate_i(half_rate_i),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dat0(in_dat0), .in_dat1(in_dat1),
    .port_data(port_data), .dr(dr)
  );

  // {ratio8, wide, half_rate, base sample}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b0, 10'h100},
    {1'b0, 1'b1, 1'b0, 10'h055},
    {1'b1, 1'b0, 1'b0, 10'h3F0},
    {1'b0, 1'b0, 1'b0, 10'h2A7},
    {1'b1, 1'b1, 1'b1, 10'h3FB},
    {1'b0, 1'b1, 1'b1, 10'h1C3},
    {1'b1, 1'b0, 1'b1, 10'h0FD},
    {1'b0, 1'b0, 1'b1, 10'h333}
  };

  task automatic check(input string req, input logic [NP*W-1:0] act,
                       input logic [NP*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NP*W-1:0] exp_ports(input logic r8, input logic w10,
                                                input logic [W-1:0] base);
    logic [NP*W-1:0] e = '0;
    for (int p = 0; p < NP; p++) begin
      logic [W-1:0] v = base + W'(p);
      if (!w10) v[1:0] = 2'b00;
      if (p < (r8 ? 8 : 4)) e[p*W +: W] = v;
    end
    return e;
  endfunction

  task automatic do_reset(input logic r8, input logic w10, input logic hr);
    @(negedge clk);
    ratio8_i = r8; wide_i = w10; half_rate_i = hr;
    in_valid = 1'b0; srst = 1'b0; arst = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset ports", port_data, '0);
    check("R8 reset dr", {79'd0, dr}, '0);
    arst = 1'b0;
  endtask

  // Returns at the negedge right after the last beat's accepting edge.
  task automatic send_group(input logic [W-1:0] base, input int n,
                            input logic hr, input bit gap);
    for (int i = 0; i < n; i += (hr ? 2 : 1)) begin
      if (gap && i != 0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_dat0  = base + W'(i);
      in_dat1  = base + W'(i + 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [NP*W-1:0] e, p1;
    int hc, hexp;
    repeat (2) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 per mode combination
    for (int v = 0; v < 8; v++) begin
      logic r8, w10, hr;
      logic [W-1:0] base;
      {r8, w10, hr, base} = VEC[v];
      do_reset(r8, w10, hr);
      send_group(base, r8 ? 8 : 4, hr, 1'b0);
      @(negedge clk);
      check("R5 no update at k+1", port_data, '0);
      check("R5 dr low at k+1", {79'd0, dr}, '0);
      @(negedge clk);
      e = exp_ports(r8, w10, base);
      check("R1/R2/R3/R4 group at k+2", port_data, e);
      check("R7 dr rises with update", {79'd0, dr}, 80'd1);
      hc = dr ? 1 : 0;
      repeat (11) begin
        @(negedge clk);
        hc += dr ? 1 : 0;
      end
      hexp = hr ? (r8 ? 2 : 1) : (r8 ? 4 : 2);
      check("R7 dr high clocks", 80'(hc), 80'(hexp));
      check("R6 ports held", port_data, e);
    end

    // R11: idle cycles inside a group
    do_reset(1'b1, 1'b1, 1'b0);
    send_group(10'h2E0, 8, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    check("R11 gapped group", port_data, exp_ports(1'b1, 1'b1, 10'h2E0));

    // R9: realignment mid-group
    do_reset(1'b1, 1'b1, 1'b0);
    send_group(10'h040, 8, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    p1 = port_data;
    check("R9 first group", p1, exp_ports(1'b1, 1'b1, 10'h040));
    send_group(10'h200, 3, 1'b0, 1'b0);
    @(negedge clk);
    srst = 1'b1; in_valid = 1'b1; in_dat0 = 10'h3FF;
    #1;
    check("R9 ready low in srst", {79'd0, in_ready}, '0);
    @(negedge clk);
    srst = 1'b0; in_valid = 1'b0;
    check("R9 ports untouched", port_data, p1);
    send_group(10'h080, 8, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R9 realigned group", port_data, exp_ports(1'b1, 1'b1, 10'h080));

    // R10: select change without reset is ignored
    do_reset(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    ratio8_i = 1'b1; wide_i = 1'b0;
    send_group(10'h123, 4, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R10 still 1:4 10-bit", port_data, exp_ports(1'b0, 1'b1, 10'h123));
    check("R10 dr after 4 samples", {79'd0, dr}, 80'd1);

    // R8: asynchronous clear before any edge
    @(negedge clk);
    arst = 1'b1;
    #2;
    check("R8 immediate ports clear", port_data, '0);
    check("R8 immediate dr clear", {79'd0, dr}, '0);
    @(negedge clk);
    arst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule